// File: doc/BRIEF.md
# Level and Edge Trigger Unit

This block watches a bank of logic channels that are sampled together as one word on every clock. Once armed, it evaluates each new sample against a trigger condition and emits a single-cycle trigger pulse on the first sample that satisfies it. After the pulse it disarms itself. It stays quiet until it is armed again.

The condition has two parts. The first is a level condition. It can be placed on any number of channels at once, and it names the required value of each chosen channel. The second is an optional edge condition on exactly one channel, which is selected by index. The edge part is ANDed with the level part, so both must hold in the same sample. A sample is compared with the one taken in the previous cycle to detect the edge. That previous sample is refreshed at the moment of arming, so data from before arming can never produce an edge.

The configuration arrives as static register inputs that software cannot read back. Every setting therefore has a defined reset value.

Top module: `trig_lvl_edge`

## Requirements
- R1: While reset is held and in the first cycle after it, `trig_o` and `armed_o` are 0.
- R2: A cycle with `arm_i`=1 and `clr_i`=0 makes `armed_o` 1 after that clock edge. The arming cycle's own sample is not evaluated. Evaluation starts with the sample of the next cycle, and a hit raises `trig_o` just after the edge that captured the qualifying sample.
- R3: Level check: channel i passes when `lvl_en_i[i]`=0 or `smp_i[i]`==`lvl_val_i[i]`. The level part holds only when every channel passes.
- R4: Edge check on channel `edg_ch_i` when `edg_en_i`=1. With `edg_fall_i`=0 (rising), the previous sample bit is 0 and the current bit is 1. With `edg_fall_i`=1 (falling), the previous bit is 1 and the current bit is 0.
- R5: With both parts enabled, the trigger fires only in a sample where the edge and every enabled level condition hold together.
- R6: With `lvl_en_i`=0 and `edg_en_i`=0, the trigger fires on the first sample after arming.
- R7: `trig_o` is high for exactly one cycle. `armed_o` is 0 from that same cycle, and no further pulse comes until the block is armed again.
- R8: `clr_i`=1 disarms the block at the next edge and suppresses any trigger there. It takes priority over a simultaneous `arm_i`.
- R9: While the block is disarmed, no input pattern raises `trig_o`.
- R10: The previous sample is loaded when the block is armed. A channel that rose before or during the arming cycle and then stays high gives no rising edge.
- R11: Transitions on channels other than `edg_ch_i` never satisfy the edge condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 16 | Sampled logic channels |
| lvl_en_i | input | 16 | Per-channel level-condition enable |
| lvl_val_i | input | 16 | Required value per level-enabled channel |
| edg_en_i | input | 1 | Edge-condition enable |
| edg_ch_i | input | 4 | Index of the edge channel |
| edg_fall_i | input | 1 | Edge polarity: 0 rising, 1 falling |
| arm_i | input | 1 | Arm request (also reloads the previous sample) |
| clr_i | input | 1 | Disarm at once; wins over arm |
| armed_o | output | 1 | Block is waiting for its condition |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The assertions check several properties on every cycle. They check that the pulse is single-cycle, that it only follows an armed cycle, and that it coincides with disarming. They check that clear and arm take effect at the next edge. They also check that every pulse comes from a sample meeting the level mask and the chosen edge polarity. Other behaviours need the bench's sequences to show them. These are the firing on the first sample with nothing enabled, the rejection of stale pre-arm data, the blindness to edges on unselected channels, and the absence of triggers while disarmed. For these, the bench's model predicts each cycle across directed cases and many random configurations.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int CH_N  = 16;
    localparam int IDX_W = $clog2(CH_N);

    typedef logic [CH_N-1:0]  word_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;

    typedef struct packed {
        word_t     lvl_en;
        word_t     lvl_val;
        logic      edg_en;
        idx_t      edg_ch;
        edge_pol_e edg_pol;
    } trig_cfg_t;

    // Transition test for one bit pair (old -> new) under a polarity.
    function automatic logic edge_seen(input logic old_b, input logic new_b,
                                       input edge_pol_e pol);
        logic hit;
        if (pol == EDGE_FALL) hit = old_b & ~new_b;
        else                  hit = ~old_b & new_b;
        return hit;
    endfunction

    // One channel passes its level test when unmasked or equal to the target.
    function automatic logic level_bit_ok(input logic en, input logic want,
                                          input logic got);
        return ~en | ~(want ^ got);
    endfunction

endpackage

// File: rtl/trig_level_match.sv
module trig_level_match #(
    parameter int CH_N = trig_pkg::CH_N
) (
    input  logic [CH_N-1:0] smp_i,
    input  logic [CH_N-1:0] en_i,
    input  logic [CH_N-1:0] val_i,
    output logic            pass_o
);
    import trig_pkg::*;

    logic [CH_N-1:0] ch_ok;

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        assign ch_ok[g] = level_bit_ok(en_i[g], val_i[g], smp_i[g]);
    end

    assign pass_o = &ch_ok;

endmodule

// File: rtl/trig_edge_detect.sv
module trig_edge_detect #(
    parameter int CH_N  = trig_pkg::CH_N,
    localparam int IDX_W = $clog2(CH_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CH_N-1:0]  smp_i,
    input  logic             en_i,
    input  logic [IDX_W-1:0] ch_i,
    input  trig_pkg::edge_pol_e pol_i,
    output logic             pass_o
);
    import trig_pkg::*;

    logic [CH_N-1:0] prev_q;
    logic            old_bit;
    logic            new_bit;

    // Previous sample: refreshed whenever arming or armed, so the first
    // comparison after arming always uses the arming-cycle sample.
    always_ff @(posedge clk) begin
        if (rst)         prev_q <= '0;
        else if (load_i) prev_q <= smp_i;
    end

    assign old_bit = prev_q[ch_i];
    assign new_bit = smp_i[ch_i];
    assign pass_o  = ~en_i | edge_seen(old_bit, new_bit, pol_i);

endmodule

// File: rtl/trig_arm_ctrl.sv
module trig_arm_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic clr_i,
    input  logic hit_i,
    output logic load_o,
    output logic armed_o,
    output logic trig_o
);
    import trig_pkg::*;

    arm_state_e st_q, st_d;
    logic       trig_d;
    logic       eval;

    // A sample is judged only while armed and neither clear nor re-arm.
    assign eval = (st_q == ST_ARMED) & ~arm_i & ~clr_i;

    always_comb begin
        st_d   = st_q;
        trig_d = 1'b0;
        if (clr_i) begin
            st_d = ST_IDLE;
        end else if (arm_i) begin
            st_d = ST_ARMED;
        end else if (eval && hit_i) begin
            st_d   = ST_IDLE;
            trig_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            trig_o <= 1'b0;
        end else begin
            st_q   <= st_d;
            trig_o <= trig_d;
        end
    end

    assign load_o  = arm_i | (st_q == ST_ARMED);
    assign armed_o = (st_q == ST_ARMED);

endmodule

// File: rtl/trig_lvl_edge.sv
module trig_lvl_edge #(
    parameter int CH_N  = trig_pkg::CH_N,
    localparam int IDX_W = $clog2(CH_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CH_N-1:0]  smp_i,
    input  logic [CH_N-1:0]  lvl_en_i,
    input  logic [CH_N-1:0]  lvl_val_i,
    input  logic             edg_en_i,
    input  logic [IDX_W-1:0] edg_ch_i,
    input  logic             edg_fall_i,
    input  logic             arm_i,
    input  logic             clr_i,
    output logic             armed_o,
    output logic             trig_o
);
    import trig_pkg::*;

    edge_pol_e pol;
    logic      lvl_pass;
    logic      edg_pass;
    logic      load;

    assign pol = edg_fall_i ? EDGE_FALL : EDGE_RISE;

    trig_level_match #(.CH_N(CH_N)) u_lvl (
        .smp_i  (smp_i),
        .en_i   (lvl_en_i),
        .val_i  (lvl_val_i),
        .pass_o (lvl_pass)
    );

    trig_edge_detect #(.CH_N(CH_N)) u_edg (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .smp_i  (smp_i),
        .en_i   (edg_en_i),
        .ch_i   (edg_ch_i),
        .pol_i  (pol),
        .pass_o (edg_pass)
    );

    trig_arm_ctrl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .arm_i   (arm_i),
        .clr_i   (clr_i),
        .hit_i   (lvl_pass & edg_pass),
        .load_o  (load),
        .armed_o (armed_o),
        .trig_o  (trig_o)
    );

endmodule

// File: rtl/trig_lvl_edge_chk.sv
module trig_lvl_edge_chk #(
    parameter int CH_N  = trig_pkg::CH_N,
    localparam int IDX_W = $clog2(CH_N)
) (
    input logic             clk,
    input logic             rst,
    input logic [CH_N-1:0]  smp_i,
    input logic [CH_N-1:0]  lvl_en_i,
    input logic [CH_N-1:0]  lvl_val_i,
    input logic             edg_en_i,
    input logic [IDX_W-1:0] edg_ch_i,
    input logic             edg_fall_i,
    input logic             arm_i,
    input logic             clr_i,
    input logic             armed_o,
    input logic             trig_o
);
    logic sel_bit;
    logic lvl_bad;

    assign sel_bit = smp_i[edg_ch_i];
    assign lvl_bad = |((smp_i ^ lvl_val_i) & lvl_en_i);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);

    a_r7_disarm_on_fire: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> !armed_o);

    a_r9_fire_needs_armed: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> $past(armed_o) && !$past(arm_i) && !$past(clr_i));

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !armed_o && !trig_o);

    a_r2_arm_sets: assert property (@(posedge clk) disable iff (rst)
        (arm_i && !clr_i) |=> armed_o && !trig_o);

    a_r3_level_on_fire: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> !$past(lvl_bad));

    a_r4_rise_on_fire: assert property (@(posedge clk) disable iff (rst)
        (trig_o && $past(edg_en_i) && !$past(edg_fall_i))
            |-> $past(sel_bit) && !$past(sel_bit, 2));

    a_r4_fall_on_fire: assert property (@(posedge clk) disable iff (rst)
        (trig_o && $past(edg_en_i) && $past(edg_fall_i))
            |-> !$past(sel_bit) && $past(sel_bit, 2));

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !trig_o && !armed_o);

endmodule

bind trig_lvl_edge trig_lvl_edge_chk #(.CH_N(CH_N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_i      (smp_i),
    .lvl_en_i   (lvl_en_i),
    .lvl_val_i  (lvl_val_i),
    .edg_en_i   (edg_en_i),
    .edg_ch_i   (edg_ch_i),
    .edg_fall_i (edg_fall_i),
    .arm_i      (arm_i),
    .clr_i      (clr_i),
    .armed_o    (armed_o),
    .trig_o     (trig_o)
);

// File: tb/trig_lvl_edge_bench.sv
module trig_lvl_edge_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] smp_i = '0;
    logic [15:0] lvl_en_i = '0;
    logic [15:0] lvl_val_i = '0;
    logic        edg_en_i = 1'b0;
    logic [3:0]  edg_ch_i = '0;
    logic        edg_fall_i = 1'b0;
    logic        arm_i = 1'b0;
    logic        clr_i = 1'b0;
    logic        armed_o;
    logic        trig_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic        m_armed = 1'b0;
    logic        m_trig = 1'b0;
    logic [15:0] m_prev = '0;

    always #10 clk = ~clk;

    trig_lvl_edge u_trig_lvl_edge (
        .clk(clk), .rst(rst), .smp_i(smp_i), .lvl_en_i(lvl_en_i),
        .lvl_val_i(lvl_val_i), .edg_en_i(edg_en_i), .edg_ch_i(edg_ch_i),
        .edg_fall_i(edg_fall_i), .arm_i(arm_i), .clr_i(clr_i),
        .armed_o(armed_o), .trig_o(trig_o)
    );

    function automatic logic want_fire(input logic [15:0] prv, input logic [15:0] cur);
        logic lvl_ok;
        logic edg_ok;
        lvl_ok = (((cur ^ lvl_val_i) & lvl_en_i) == 16'h0);
        if (!edg_en_i)       edg_ok = 1'b1;
        else if (edg_fall_i) edg_ok = prv[edg_ch_i] && !cur[edg_ch_i];
        else                 edg_ok = !prv[edg_ch_i] && cur[edg_ch_i];
        return lvl_ok && edg_ok;
    endfunction

    task automatic model_edge();
        logic f;
        if (rst) begin
            m_armed = 1'b0; m_trig = 1'b0; m_prev = '0;
        end else if (clr_i) begin
            m_armed = 1'b0; m_trig = 1'b0;
        end else if (arm_i) begin
            m_armed = 1'b1; m_trig = 1'b0; m_prev = smp_i;
        end else if (m_armed) begin
            f = want_fire(m_prev, smp_i);
            m_prev = smp_i;
            m_trig = f;
            if (f) m_armed = 1'b0;
        end else begin
            m_trig = 1'b0;
        end
    endtask

    task automatic compare(input string req);
        n_cmp++;
        if (trig_o !== m_trig) begin
            n_bad++;
            $display("FAIL %s trig_o actual=%b expected=%b t=%0t", req, trig_o, m_trig, $time);
        end
        n_cmp++;
        if (armed_o !== m_armed) begin
            n_bad++;
            $display("FAIL %s armed_o actual=%b expected=%b t=%0t", req, armed_o, m_armed, $time);
        end
    endtask

    // Inputs are set at the falling edge; one rising edge; checked at next fall.
    task automatic step(input logic [15:0] s, input logic a, input logic c, input string req);
        smp_i = s; arm_i = a; clr_i = c;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
    endtask

    task automatic set_cfg(input logic [15:0] en, input logic [15:0] val,
                           input logic ee, input logic [3:0] ch, input logic fall);
        lvl_en_i = en; lvl_val_i = val; edg_en_i = ee; edg_ch_i = ch; edg_fall_i = fall;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        @(negedge clk);
        // R1: outputs quiet during and right after reset
        compare("R1");
        step(16'hFFFF, 1'b1, 1'b0, "R1");
        rst = 1'b0;
        step(16'h0000, 1'b0, 1'b0, "R1");

        // R6: nothing enabled fires on the first sample after arming
        set_cfg(16'h0, 16'h0, 1'b0, 4'd0, 1'b0);
        step(16'h1234, 1'b1, 1'b0, "R2 R6");
        step(16'h4321, 1'b0, 1'b0, "R6");
        step(16'h4321, 1'b0, 1'b0, "R7");
        step(16'h4321, 1'b0, 1'b0, "R7");

        // R9: disarmed, matching pattern does nothing
        set_cfg(16'h00F0, 16'h0050, 1'b0, 4'd0, 1'b0);
        for (int i = 0; i < 4; i++) step(16'h0050, 1'b0, 1'b0, "R9");

        // R3: level match on masked channels
        step(16'h0000, 1'b1, 1'b0, "R2");
        step(16'h0070, 1'b0, 1'b0, "R3");
        step(16'hFF0F, 1'b0, 1'b0, "R3");
        step(16'hAB5C, 1'b0, 1'b0, "R3");
        step(16'h0000, 1'b0, 1'b0, "R7");

        // R4: rising edge on channel 5
        set_cfg(16'h0, 16'h0, 1'b1, 4'd5, 1'b0);
        step(16'h0000, 1'b1, 1'b0, "R2");
        step(16'h0000, 1'b0, 1'b0, "R4");
        step(16'h0020, 1'b0, 1'b0, "R4");
        step(16'h0000, 1'b0, 1'b0, "R7");

        // R4: falling edge on channel 12
        set_cfg(16'h0, 16'h0, 1'b1, 4'd12, 1'b1);
        step(16'h1000, 1'b1, 1'b0, "R2");
        step(16'h1000, 1'b0, 1'b0, "R4");
        step(16'h0000, 1'b0, 1'b0, "R4");

        // R11: edges on other channels ignored
        set_cfg(16'h0, 16'h0, 1'b1, 4'd3, 1'b0);
        step(16'h0000, 1'b1, 1'b0, "R11");
        step(16'hFFF7, 1'b0, 1'b0, "R11");
        step(16'h0000, 1'b0, 1'b0, "R11");
        step(16'hFFF7, 1'b0, 1'b0, "R11");
        step(16'h0008, 1'b0, 1'b0, "R11");

        // R5: edge without level, then both
        set_cfg(16'h0003, 16'h0001, 1'b1, 4'd8, 1'b0);
        step(16'h0000, 1'b1, 1'b0, "R5");
        step(16'h0100, 1'b0, 1'b0, "R5");
        step(16'h0001, 1'b0, 1'b0, "R5");
        step(16'h0101, 1'b0, 1'b0, "R5");
        step(16'h0000, 1'b0, 1'b0, "R7");

        // R10: channel rose in the arming cycle and stays high
        set_cfg(16'h0, 16'h0, 1'b1, 4'd9, 1'b0);
        step(16'h0000, 1'b0, 1'b0, "R10");
        step(16'h0200, 1'b1, 1'b0, "R10");
        step(16'h0200, 1'b0, 1'b0, "R10");
        step(16'h0200, 1'b0, 1'b0, "R10");
        step(16'h0000, 1'b0, 1'b0, "R10");
        step(16'h0200, 1'b0, 1'b0, "R10");

        // R8: clear disarms, blocks a pending hit, wins over arm
        set_cfg(16'h0, 16'h0, 1'b0, 4'd0, 1'b0);
        step(16'h0000, 1'b1, 1'b0, "R8");
        step(16'h0000, 1'b0, 1'b1, "R8");
        step(16'h0000, 1'b1, 1'b1, "R8");
        step(16'h0000, 1'b0, 1'b0, "R8");

        // constrained random episodes
        for (int ep = 0; ep < 400; ep++) begin
            logic [15:0] en;
            logic [15:0] val;
            int len;
            en  = 16'($urandom) & 16'($urandom);
            val = 16'($urandom);
            step(16'($urandom), 1'b0, 1'b0, "R9");
            set_cfg(en, val, 1'($urandom), 4'($urandom), 1'($urandom));
            step(16'($urandom), 1'b0, 1'b0, "R9");
            step(16'($urandom), 1'b1, 1'b0, "R2");
            len = 4 + int'($urandom % 12);
            for (int k = 0; k < len; k++) begin
                logic [15:0] s;
                logic a;
                logic c;
                s = 16'($urandom);
                if ($urandom % 2 == 0) s = (s & ~en) | (val & en);
                a = ($urandom % 20 == 0);
                c = ($urandom % 25 == 0);
                step(s, a, c, "R3 R4 R5 R7 R8");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule